// File: doc/BRIEF.md
# Delayed Even-Parity Generator and Checker

This block produces and checks one even-parity bit that covers a 32-bit multiplexed address/data bus together with its 4-bit command/byte-enable field. The parity bit always trails the bus by one clock. An agent that drives the bus in some cycle drives the matching parity bit in the next cycle. An agent that receives the bus in some cycle compares the parity that arrives in the next cycle against its own result. On a mismatch it raises a one-cycle error pulse.

The receiver side needs to know who owns each bus cycle. A small phase state machine follows the transaction to find this out. The machine has three states. `PH_IDLE` means no transaction is open; a cycle in this state with `frame` high is the address phase. `PH_WDATA` means the open transaction is a write. `PH_RDATA` means it is a read. There are three kinds of transition. Transition `T_START` leaves `PH_IDLE` on an address phase; `bus_cmd[0]` picks `PH_WDATA` (1) or `PH_RDATA` (0). Transition `T_LAST` returns to `PH_IDLE` when a data phase completes (`irdy` and `trdy` both high) while `frame` is low. Transition `T_HOLD` keeps the current state in every other case.

All qualifiers on the ports are active high. `is_initiator` gives this agent's role in the current transaction. `ad_oe` is this agent's own output enable for the bus.

Top module: `bus_parity_tracker`

## Requirements
- R1: In every cycle after reset, `par_out` equals the XOR of all bits of `bus_data` and `bus_cmd` sampled on the previous clock edge, so the parity tracks the bus with a delay of one clock.
- R2: `par_oe` equals `ad_oe` sampled on the previous clock edge.
- R3: While `rst_n` is low, `par_out`, `par_oe` and `par_err` are all 0. The parity line is never driven high during reset.
- R4: A cycle in `PH_IDLE` with `frame` high is an address phase. If `is_initiator` is 0 in that cycle, the parity received in the next cycle is checked.
- R5: In a write transaction (`bus_cmd[0]`=1 in the address phase), a cycle with `irdy` high and `is_initiator` 0 is checked.
- R6: In a read transaction (`bus_cmd[0]`=0 in the address phase), a cycle with `trdy` high and `is_initiator` 1 is checked.
- R7: For a checked cycle, `par_err` is 1 for exactly one cycle, two clocks after that bus cycle, if `par_in` in the following cycle differs from the even parity of the checked cycle. If the two agree, `par_err` stays 0.
- R8: For a cycle that is not checked (this agent is the driver, or the qualifier is low), `par_in` in the following cycle has no effect on `par_err`.
- R9: A data phase with `irdy` and `trdy` high while `frame` is low ends the transaction. The next cycle with `frame` high is a new address phase, and its command bit is decoded afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_data | input | 32 | Sampled address/data bus |
| bus_cmd | input | 4 | Sampled command / byte-enable field |
| frame | input | 1 | Transaction in progress (active high) |
| irdy | input | 1 | Initiator ready (active high) |
| trdy | input | 1 | Target ready (active high) |
| is_initiator | input | 1 | 1 when this agent is the initiator of the transaction |
| ad_oe | input | 1 | This agent's bus output enable |
| par_in | input | 1 | Parity bit received from the bus |
| par_out | output | 1 | Generated parity, one clock behind the bus |
| par_oe | output | 1 | Parity output enable, one clock behind `ad_oe` |
| par_err | output | 1 | One-cycle parity error pulse |

## Verification
Some properties are checked by assertions on every cycle. These are the one-clock lag of `par_out` and `par_oe` behind the bus and the enable, the quiet outputs during reset, the state changes on an address phase and on a final data phase, and a rule about every error pulse. That rule says a pulse must follow a checked cycle and a received bit that really differed from the parity of the data two clocks earlier. Other behaviour needs the bench's scenarios. These scenarios show which cycles count as received, depending on role and direction: the target checks the address and write data, and the initiator checks read data. They show that corrupted parity during wait states or self-driven cycles goes unreported. They also cover a new address phase that follows a final data phase with no idle cycle between them.

// File: rtl/bpar_pkg.sv
package bpar_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WDATA = 2'd1,
        PH_RDATA = 2'd2
    } bus_phase_e;

    // position of the write flag inside the command field
    localparam int unsigned WR_CMD_BIT = 0;
endpackage

// File: rtl/bpar_phase_fsm.sv
module bpar_phase_fsm
    import bpar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame,
    input  logic irdy,
    input  logic trdy,
    input  logic is_initiator,
    input  logic cmd_write,
    output logic recv_valid
);
    bus_phase_e state_q;
    bus_phase_e state_d;
    logic       data_done;

    assign data_done = irdy && trdy;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: T_START, T_LAST, T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: begin
                if (frame) begin
                    state_d = cmd_write ? PH_WDATA : PH_RDATA;
                end
            end
            PH_WDATA, PH_RDATA: begin
                if (data_done && !frame) begin
                    state_d = PH_IDLE;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // outputs: which cycles carry parity this agent receives
    always_comb begin
        recv_valid = 1'b0;
        unique case (state_q)
            PH_IDLE:  recv_valid = frame && !is_initiator;
            PH_WDATA: recv_valid = irdy && !is_initiator;
            PH_RDATA: recv_valid = trdy && is_initiator;
            default:  recv_valid = 1'b0;
        endcase
    end

    AST_START_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_IDLE && frame) |=> (state_q != PH_IDLE)); // R4

    AST_LAST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PH_IDLE && irdy && trdy && !frame) |=> (state_q == PH_IDLE)); // R9
endmodule

// File: rtl/bpar_gen.sv
module bpar_gen #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CMD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [CMD_W-1:0]  bus_cmd,
    input  logic              ad_oe,
    output logic              cur_par,
    output logic              par_out,
    output logic              par_oe
);
    localparam int unsigned COVER_W = DATA_W + CMD_W;

    logic [COVER_W-1:0] covered;

    assign covered = {bus_cmd, bus_data};
    assign cur_par = ^covered;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_out <= 1'b0;
            par_oe  <= 1'b0;
        end else begin
            par_out <= cur_par;
            par_oe  <= ad_oe;
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (par_out == 1'b0 && par_oe == 1'b0); // R3
        end
    end
endmodule

// File: rtl/bpar_chk.sv
module bpar_chk (
    input  logic clk,
    input  logic rst_n,
    input  logic recv_valid,
    input  logic cur_par,
    input  logic par_in,
    output logic par_err
);
    logic chk_q;
    logic exp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_q   <= 1'b0;
            exp_q   <= 1'b0;
            par_err <= 1'b0;
        end else begin
            chk_q   <= recv_valid;
            exp_q   <= cur_par;
            par_err <= chk_q && (par_in != exp_q);
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_ERR_QUIET_RESET: assert (par_err == 1'b0); // R3
        end
    end
endmodule

// File: rtl/bus_parity_tracker.sv
module bus_parity_tracker
    import bpar_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CMD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [CMD_W-1:0]  bus_cmd,
    input  logic              frame,
    input  logic              irdy,
    input  logic              trdy,
    input  logic              is_initiator,
    input  logic              ad_oe,
    input  logic              par_in,
    output logic              par_out,
    output logic              par_oe,
    output logic              par_err
);
    logic recv_valid;
    logic cur_par;

    bpar_phase_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame        (frame),
        .irdy         (irdy),
        .trdy         (trdy),
        .is_initiator (is_initiator),
        .cmd_write    (bus_cmd[WR_CMD_BIT]),
        .recv_valid   (recv_valid)
    );

    bpar_gen #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_data (bus_data),
        .bus_cmd  (bus_cmd),
        .ad_oe    (ad_oe),
        .cur_par  (cur_par),
        .par_out  (par_out),
        .par_oe   (par_oe)
    );

    bpar_chk u_chk (
        .clk        (clk),
        .rst_n      (rst_n),
        .recv_valid (recv_valid),
        .cur_par    (cur_par),
        .par_in     (par_in),
        .par_err    (par_err)
    );

    AST_PAR_LAGS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (par_out == $past(^{bus_cmd, bus_data}))); // R1

    AST_OE_LAGS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (par_oe == $past(ad_oe))); // R2

    AST_ERR_REAL_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> ($past(par_in) != $past(^{bus_cmd, bus_data}, 2))); // R7

    AST_ERR_ONLY_RECEIVED: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> $past(recv_valid, 2)); // R8
endmodule

// File: tb/bus_parity_tracker_test.sv
module bus_parity_tracker_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] bus_data;
    logic [3:0]  bus_cmd;
    logic        frame, irdy, trdy, is_initiator, ad_oe, par_in;
    logic        par_out, par_oe, par_err;

    always #2 clk = ~clk;

    bus_parity_tracker uut (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_cmd(bus_cmd),
        .frame(frame), .irdy(irdy), .trdy(trdy), .is_initiator(is_initiator),
        .ad_oe(ad_oe), .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
        .par_err(par_err)
    );

    typedef struct {
        int    due;
        int    kind;
        logic  val;
        string req;
    } item_t;

    item_t q[$];
    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    done = 0;
    logic  pend_par = 1'b0;
    bit    pend_recv = 0;
    string pend_req = "R8";

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // driver: applies one bus cycle and pushes the expected results
    task automatic step(input logic [31:0] d, input logic [3:0] c,
                        input bit fr, input bit ir, input bit tr,
                        input bit init, input bit oe, input bit recv,
                        input bit flip, input string req);
        item_t it;
        @(negedge clk);
        bus_data     = d;
        bus_cmd      = c;
        frame        = fr;
        irdy         = ir;
        trdy         = tr;
        is_initiator = init;
        ad_oe        = oe;
        par_in       = pend_par ^ flip;
        it.due = cyc + 1; it.kind = 0; it.val = ^{c, d};            it.req = "R1";     q.push_back(it);
        it.due = cyc + 1; it.kind = 1; it.val = oe;                 it.req = "R2";     q.push_back(it);
        it.due = cyc + 1; it.kind = 2; it.val = pend_recv && flip;  it.req = pend_req; q.push_back(it);
        pend_par  = ^{c, d};
        pend_recv = recv;
        pend_req  = req;
    endtask

    task automatic idle(input bit flip, input string req);
        step(32'h0, 4'h0, 0, 0, 0, 0, 0, 0, flip, req);
    endtask

    // monitor: pops expectations as results appear
    always @(posedge clk) begin
        cyc = cyc + 1;
        #1;
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            case (it.kind)
                0:       check(it.req, par_out, it.val);
                1:       check(it.req, par_oe, it.val);
                default: check({it.req, " err"}, par_err, it.val);
            endcase
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        bus_data = 32'hFFFF_FFFE; bus_cmd = 4'h0;
        frame = 1; irdy = 1; trdy = 1; is_initiator = 0; ad_oe = 1; par_in = 1;
        repeat (3) @(negedge clk);
        check("R3 par_out", par_out, 1'b0);
        check("R3 par_oe", par_oe, 1'b0);
        check("R3 par_err", par_err, 1'b0);
        frame = 0; irdy = 0; trdy = 0; ad_oe = 0; par_in = 0; bus_data = 0;
        @(negedge clk);
        rst_n = 1'b1;

        // target of a write: address and write data are received
        step(32'h1234_5678, 4'b0111, 1, 0, 0, 0, 0, 1, 0, "R4");
        step(32'hA5A5_0F0F, 4'b0000, 1, 1, 0, 0, 0, 1, 1, "R5");   // addr parity corrupted
        step(32'hFFFF_FFFF, 4'b0011, 1, 0, 0, 0, 0, 0, 0, "R8");   // wait state
        step(32'h0000_0001, 4'b1110, 1, 1, 1, 0, 0, 1, 1, "R5");   // flip on wait: ignored
        step(32'h8000_0000, 4'b0000, 0, 1, 1, 0, 0, 1, 1, "R5");   // last phase, prior corrupted
        idle(1, "R9");                                              // last data corrupted

        // initiator of a read: only read data is received
        step(32'hDEAD_BEEF, 4'b0110, 1, 0, 0, 1, 1, 0, 0, "R8");
        step(32'h0000_0000, 4'b0000, 1, 1, 0, 1, 0, 0, 1, "R6");   // own addr: flip ignored
        step(32'h5555_AAAA, 4'b0101, 1, 1, 1, 1, 0, 1, 1, "R6");   // trdy low before: ignored
        step(32'h7FFF_FFFF, 4'b1111, 0, 1, 1, 1, 0, 1, 1, "R6");   // catches corruption above
        idle(0, "R9");                                              // match: no error

        // target of a read: address received, read data self-driven
        step(32'h0F0F_0F0F, 4'b1010, 1, 0, 0, 0, 0, 1, 0, "R4");
        step(32'h1111_1111, 4'b0000, 0, 1, 1, 0, 1, 0, 0, "R8");
        idle(1, "R8");

        // initiator of a write: nothing received
        step(32'hCAFE_F00D, 4'b0011, 1, 0, 0, 1, 1, 0, 0, "R8");
        step(32'h0000_FFFF, 4'b0001, 0, 1, 1, 1, 1, 0, 1, "R8");
        // new address phase immediately after the final phase
        step(32'h2468_ACE0, 4'b1111, 1, 0, 0, 0, 0, 1, 1, "R9");
        step(32'h1357_9BDF, 4'b0000, 0, 1, 1, 0, 0, 1, 1, "R5");   // addr corrupted
        idle(0, "R9");
        idle(0, "R9");
        idle(0, "R9");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule